// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a register-mapped watchdog. A down-counter is loaded from a programmable reload value. While counting is enabled, the counter steps down once per count step. Software keeps the watchdog alive by writing one fixed key word to a service register, which reloads the counter. If software stops servicing, the counter runs out. It then reloads itself, latches a sticky timeout flag and, depending on the control word, does the following:
- issues a one-cycle reset request tagged with a reset-domain code;
- strobes an external trigger;
- latches a sticky flag that asks the next boot to use the secondary image.

An optional early-warning interrupt fires when the falling count lands on a threshold held in the upper part of the control word. Software clears all sticky status through a write-to-clear register.

Count steps come from one of two sources. A one-cycle tick enable input (nominally 1 MHz) is the first. The bus clock is the second, where every cycle is a step. A control bit selects the source. Read data is registered, so it is returned one cycle after the address is presented.

Top module: `wdog_timer`

## Requirements
- R1: After reset:
  - the counter and the reload register both hold RELOAD_RST (default 0x01E84800);
  - control and status read as zero;
  - rst_req, ext_pulse, irq and boot_alt are low.
- R2: The service register is at byte offset 0x08. Writing exactly 0x00004755 there loads the counter from the reload register. Any other value written there leaves the counter unchanged.
- R3: Control bit 0 enables counting. Control bit 4 selects the step source:
  - when it is 1, the counter decrements once per cycle with tick_1us high;
  - when it is 0, the counter decrements on every clock.
- R4: When control bit 0 is cleared, the counter holds its value. Setting the bit again resumes counting from the held value, with no reload.
- R5: A step taken while the counter is zero is an expiry. An expiry reloads the counter and sets status bit 0 (timeout). With reload value N, expiry therefore occurs on step N+1 after a service write.
- R6: When control bit 1 is set, an expiry raises rst_req for exactly one cycle. rst_mode always shows control bits 6:5: 0 for the SoC, 1 for the full chip, 2 for the CPU only.
- R7: When control bit 3 is set, an expiry raises ext_pulse for exactly one cycle. When the bit is clear, an expiry gives no pulse.
- R8: An expiry with control bit 7 set sets status bit 1. boot_alt follows status bit 1 and stays high across later expiries until it is cleared.
- R9: When control bit 2 is set, a step that brings the counter to {control[31:10], 10'b0} sets status bit 2. irq follows status bit 2 and stays high until it is cleared. When control bit 2 is clear, such a step has no effect.
- R10: The clear register is at offset 0x14. A write there with bit 0 set clears status bits 2:0. A write with bit 0 clear changes nothing.
- R11: The register map is:
  - offset 0x00: live count;
  - offset 0x04: reload value (read/write);
  - offset 0x0C: control word (read/write);
  - offset 0x10: status, read as {29'b0, early-warning, boot-secondary, timeout}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle count tick (nominal 1 MHz) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after addr |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_mode | output | 2 | Reset-domain code from control bits 6:5 |
| irq | output | 1 | Early-warning interrupt, sticky |
| ext_pulse | output | 1 | One-cycle external trigger on expiry |
| boot_alt | output | 1 | Sticky secondary-boot request |

## Verification
The bench probes the expiry boundary. It steps the counter down to zero and checks that no reset has yet appeared. One more step must then produce the pulse. An off-by-one design would reset a step early or a step late.

A near-miss service key must leave the count alone. A design that compares only some of the key bits would reload on it.

The bench freezes the counter, resumes it and reads back the held value. A design that reloads on enable would show the full reload value instead.

The early-warning threshold is checked one step before and exactly on the crossing, with the interrupt bit both set and clear. The sticky flags are checked across a second expiry and across a clear write with bit 0 low. Each check catches flags that self-clear or that clear on any write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // byte offsets
  localparam int A_COUNT   = 0;
  localparam int A_RELOAD  = 4;
  localparam int A_KICK    = 8;
  localparam int A_CTRL    = 12;
  localparam int A_STATUS  = 16;
  localparam int A_CLEAR   = 20;

  localparam logic [31:0] KICK_KEY = 32'h0000_4755;

  // control bit positions
  localparam int C_EN      = 0;
  localparam int C_SYS     = 1;
  localparam int C_PRE     = 2;
  localparam int C_EXT     = 3;
  localparam int C_TSEL    = 4;
  localparam int C_MODE_LO = 5;
  localparam int C_BOOT    = 7;
  localparam int THR_LSB   = 10;

  // status bit positions
  localparam int S_TMO     = 0;
  localparam int S_BOOT    = 1;
  localparam int S_PRE     = 2;
  localparam int ST_W      = 3;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 5,
  parameter logic [31:0] RELOAD_RST = 32'h01E8_4800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [ST_W-1:0]   status_i,
  output logic [DATA_W-1:0] reload_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              kick_o,
  output logic              clear_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] AD_COUNT  = ADDR_W'(A_COUNT);
  localparam logic [ADDR_W-1:0] AD_RELOAD = ADDR_W'(A_RELOAD);
  localparam logic [ADDR_W-1:0] AD_KICK   = ADDR_W'(A_KICK);
  localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(A_STATUS);
  localparam logic [ADDR_W-1:0] AD_CLEAR  = ADDR_W'(A_CLEAR);

  assign kick_o  = wr_en_i && (addr_i == AD_KICK) && (wdata_i == DATA_W'(KICK_KEY));
  assign clear_o = wr_en_i && (addr_i == AD_CLEAR) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_o <= DATA_W'(RELOAD_RST);
      ctrl_o   <= '0;
    end else if (wr_en_i) begin
      if (addr_i == AD_RELOAD) reload_o <= wdata_i;
      if (addr_i == AD_CTRL)   ctrl_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      case (addr_i)
        AD_COUNT:  rdata_o <= count_i;
        AD_RELOAD: rdata_o <= reload_o;
        AD_CTRL:   rdata_o <= ctrl_o;
        AD_STATUS: rdata_o <= DATA_W'(status_i);
        default:   rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] RELOAD_RST = 32'h01E8_4800
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_i,
  input  logic                     en_i,
  input  logic                     tsel_i,
  input  logic                     sys_en_i,
  input  logic                     ext_en_i,
  input  logic                     pre_en_i,
  input  logic [DATA_W-THR_LSB-1:0] thr_i,
  input  logic [DATA_W-1:0]        reload_i,
  input  logic                     kick_i,
  output logic [DATA_W-1:0]        count_o,
  output logic                     expire_o,
  output logic                     pre_hit_o,
  output logic                     rst_req_o,
  output logic                     ext_pulse_o
);
  logic              step;
  logic              at_zero;
  logic [DATA_W-1:0] dec;
  logic [DATA_W-1:0] thr_val;

  assign step      = en_i && (tsel_i ? tick_i : 1'b1);
  assign at_zero   = (count_o == '0);
  assign dec       = count_o - 1'b1;
  assign thr_val   = {thr_i, {THR_LSB{1'b0}}};
  assign expire_o  = step && !kick_i && at_zero;
  assign pre_hit_o = step && !kick_i && !at_zero && pre_en_i && (dec == thr_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= DATA_W'(RELOAD_RST);
    end else if (kick_i || expire_o) begin
      count_o <= reload_i;
    end else if (step) begin
      count_o <= dec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_o   <= 1'b0;
      ext_pulse_o <= 1'b0;
    end else begin
      rst_req_o   <= expire_o && sys_en_i;
      ext_pulse_o <= expire_o && ext_en_i;
    end
  end

  // R2
  kick_load_chk: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> (count_o == $past(reload_i)));

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!kick_i && !en_i) |=> (count_o == $past(count_o)));

  // R6
  rst_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(sys_en_i));
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            expire_i,
  input  logic            boot_en_i,
  input  logic            pre_hit_i,
  input  logic            clear_i,
  output logic [ST_W-1:0] st_o
);
  logic [ST_W-1:0] set_v;

  always_comb begin
    set_v         = '0;
    set_v[S_TMO]  = expire_i;
    set_v[S_BOOT] = expire_i && boot_en_i;
    set_v[S_PRE]  = pre_hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) st_o <= '0;
    else     st_o <= (clear_i ? '0 : st_o) | set_v;
  end

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(st_o) & ~st_o)) |-> $past(clear_i));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 5,
  parameter logic [31:0] RELOAD_RST = 32'h01E8_4800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1us,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic [1:0]        rst_mode,
  output logic              irq,
  output logic              ext_pulse,
  output logic              boot_alt
);
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] ctrl;
  logic [DATA_W-1:0] count;
  logic [ST_W-1:0]   status;
  logic              kick;
  logic              clear;
  logic              expire;
  logic              pre_hit;

  wdog_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .count_i  (count),
    .status_i (status),
    .reload_o (reload),
    .ctrl_o   (ctrl),
    .kick_o   (kick),
    .clear_o  (clear),
    .rdata_o  (rdata)
  );

  wdog_counter #(.DATA_W(DATA_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_1us),
    .en_i        (ctrl[C_EN]),
    .tsel_i      (ctrl[C_TSEL]),
    .sys_en_i    (ctrl[C_SYS]),
    .ext_en_i    (ctrl[C_EXT]),
    .pre_en_i    (ctrl[C_PRE]),
    .thr_i       (ctrl[DATA_W-1:THR_LSB]),
    .reload_i    (reload),
    .kick_i      (kick),
    .count_o     (count),
    .expire_o    (expire),
    .pre_hit_o   (pre_hit),
    .rst_req_o   (rst_req),
    .ext_pulse_o (ext_pulse)
  );

  wdog_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .expire_i  (expire),
    .boot_en_i (ctrl[C_BOOT]),
    .pre_hit_i (pre_hit),
    .clear_i   (clear),
    .st_o      (status)
  );

  assign rst_mode = ctrl[C_MODE_LO+1:C_MODE_LO];
  assign irq      = status[S_PRE];
  assign boot_alt = status[S_BOOT];

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ctrl[C_PRE]));

  // R7
  ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ext_pulse |-> $past(ctrl[C_EXT]));
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1us = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;
  logic [1:0]  rst_mode;
  logic        irq;
  logic        ext_pulse;
  logic        boot_alt;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .rst_mode(rst_mode),
    .irq(irq), .ext_pulse(ext_pulse), .boot_alt(boot_alt)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int n_rst = 0;
  int n_ext = 0;
  logic rst_prev = 1'b0;
  logic ext_prev = 1'b0;

  // scoreboard: read tasks push expectations, monitor pops and compares
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_flag = 1'b0;
  logic        samp = 1'b0;
  logic [31:0] e_val;
  string       e_tag;

  always @(posedge clk) samp <= rd_flag;

  always @(negedge clk) begin
    if (samp) begin
      e_val = exp_q.pop_front();
      e_tag = tag_q.pop_front();
      n_chk++;
      if (rdata !== e_val) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected %h", e_tag, rdata, e_val);
      end
    end
    if (rst_req) n_rst++;
    if (ext_pulse) n_ext++;
    if (rst_req && rst_prev) begin
      n_fail++; n_chk++;
      $display("FAIL R6: rst_req=1 for 2 cycles expected 1");
    end
    if (ext_pulse && ext_prev) begin
      n_fail++; n_chk++;
      $display("FAIL R7: ext_pulse=1 for 2 cycles expected 1");
    end
    rst_prev = rst_req;
    ext_prev = ext_pulse;
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string t);
    @(negedge clk); addr = a; rd_flag = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(t);
    @(negedge clk); rd_flag = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1us = 1'b1;
      @(negedge clk); tick_1us = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  int r0, e0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rst_req", {31'b0, rst_req}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 boot_alt", {31'b0, boot_alt}, 0);
    check("R1 ext_pulse", {31'b0, ext_pulse}, 0);
    rd(5'h00, 32'h01E8_4800, "R1 count");
    rd(5'h0C, 32'h0, "R1 ctrl");
    rd(5'h10, 32'h0, "R1 status");

    // R2 / R3 / R4 / R11 in tick mode
    wr(5'h04, 32'd10);
    rd(5'h04, 32'd10, "R11 reload readback");
    wr(5'h08, 32'h0000_4755);
    rd(5'h00, 32'd10, "R2 key reload");
    wr(5'h0C, 32'h11);
    ticks(3);
    rd(5'h00, 32'd7, "R3 tick steps");
    wr(5'h08, 32'h0000_4756);
    wr(5'h08, 32'h0001_4755);
    rd(5'h00, 32'd7, "R2 wrong key ignored");
    wr(5'h0C, 32'h10);
    ticks(2);
    rd(5'h00, 32'd7, "R4 frozen");
    wr(5'h0C, 32'h11);
    ticks(1);
    rd(5'h00, 32'd6, "R4 resume no reload");

    // R3 clock mode
    wr(5'h0C, 32'h10);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h01);
    rd(5'h00, 32'd9, "R3 clock mode step");
    wr(5'h0C, 32'h10);
    rd(5'h00, 32'd6, "R3 clock mode count");

    // R5..R8 expiry
    wr(5'h04, 32'd3);
    wr(5'h0C, 32'hDB);
    wr(5'h08, 32'h0000_4755);
    r0 = n_rst; e0 = n_ext;
    ticks(3);
    idle(1);
    rd(5'h00, 32'd0, "R5 at zero");
    check("R5 no early reset", n_rst, r0);
    ticks(1);
    idle(1);
    check("R6 reset pulse", n_rst, r0 + 1);
    check("R7 ext pulse", n_ext, e0 + 1);
    check("R6 rst_mode", {30'b0, rst_mode}, 2);
    check("R8 boot_alt", {31'b0, boot_alt}, 1);
    rd(5'h00, 32'd3, "R5 reloaded");
    rd(5'h10, 32'h3, "R5 R8 status");

    // second expiry without reset request or boot select
    wr(5'h0C, 32'h19);
    r0 = n_rst; e0 = n_ext;
    ticks(4);
    idle(1);
    check("R6 no reset when disabled", n_rst, r0);
    check("R7 ext again", n_ext, e0 + 1);
    check("R8 boot sticky", {31'b0, boot_alt}, 1);
    wr(5'h0C, 32'h10);
    wr(5'h08, 32'h0000_4755);
    r0 = n_rst; e0 = n_ext;
    wr(5'h0C, 32'h11);
    ticks(4);
    idle(1);
    check("R7 no ext when disabled", n_ext, e0);

    // R10 clear
    wr(5'h14, 32'h2);
    rd(5'h10, 32'h3, "R10 bit0 low no effect");
    wr(5'h14, 32'h1);
    rd(5'h10, 32'h0, "R10 clear");
    check("R10 boot_alt cleared", {31'b0, boot_alt}, 0);

    // R9 early warning, threshold field 1 -> 1024
    wr(5'h0C, 32'h410);
    wr(5'h04, 32'd1030);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h415);
    ticks(5);
    idle(1);
    check("R9 before threshold", {31'b0, irq}, 0);
    ticks(1);
    idle(1);
    check("R9 at threshold", {31'b0, irq}, 1);
    rd(5'h10, 32'h4, "R9 status");
    ticks(2);
    idle(1);
    check("R9 irq held", {31'b0, irq}, 1);
    wr(5'h14, 32'h1);
    idle(1);
    check("R9 irq cleared", {31'b0, irq}, 0);
    wr(5'h0C, 32'h411);
    rd(5'h0C, 32'h411, "R11 ctrl readback");
    wr(5'h08, 32'h0000_4755);
    ticks(6);
    idle(1);
    check("R9 disabled no irq", {31'b0, irq}, 0);
    rd(5'h10, 32'h0, "R9 disabled status");

    idle(3);
    summary();
    $finish;
  end
endmodule